// File: doc/BRIEF.md
# Switch-Driven Register File with Hex Result Display

This block is a small register-file exerciser for a board with a bank of slide switches, five push buttons and one seven-segment digit. It stores eight 4-bit values. A single switch field gives the write address and also the first read address. A second field gives the second read address, and the low nibble gives the write data. Holding the centre button writes the data nibble into the addressed register on every rising clock edge.

The two read ports are combinational. The other four buttons pick what the digit shows: the first read value, the second read value, or the sum, difference or bitwise AND of the two. The chosen 4-bit result is encoded into an active-low hexadecimal segment pattern. One digit enable is driven active and the decimal point stays dark. An active-low reset clears every register at once. Its release is synchronised to the clock.

Top module: `rfd_top`

## Requirements
- R1: The block holds eight 4-bit registers. Read port 1 is addressed by `sw[6:4]` and read port 2 by `sw[9:7]`.
- R2: While `btn_center` is high at a rising clock edge, `sw[3:0]` is stored into the register addressed by `sw[6:4]`. The write is level-sensitive, so each such edge writes again, with whatever data and address are present at that edge.
- R3: Reads are combinational. A value written at an edge appears on the display within the same clock period, with no extra cycle of latency.
- R4: A register is left unchanged at any edge where `btn_center` is low, or where `sw[6:4]` selects a different register.
- R5: `rst_n` low clears all eight registers to zero without waiting for a clock edge. They stay zero while it is held low.
- R6: With no operation button pressed, the digit shows the port-1 value. With `btn_right` pressed, it shows the port-2 value.
- R7: `btn_up` shows (port1 + port2) mod 16. `btn_down` shows (port1 − port2) mod 16. `btn_left` shows port1 AND port2.
- R8: When several operation buttons are pressed together, the priority is right, then up, then down, then left.
- R9: `seg_n[6:0]` is an active-low pattern ordered g..a (bit 6 is g, bit 0 is a). The codes for 0 to F are 40,79,24,30,19,12,02,78,00,10,08,03,46,21,06,0E in hex. `seg_n[7]`, the decimal point, is always 1.
- R10: `an_n` is always 8'b11111110, so only digit 0 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | 10 | [9:7] read address 2, [6:4] read/write address 1, [3:0] write data |
| btn_center | input | 1 | Write enable (level) |
| btn_left | input | 1 | Show AND of the two read values |
| btn_right | input | 1 | Show the port-2 read value |
| btn_up | input | 1 | Show the sum |
| btn_down | input | 1 | Show the difference |
| seg_n | output | 8 | Active-low segments, bit 7 decimal point, bits 6..0 g..a |
| an_n | output | 8 | Active-low digit enables |

## Verification
The bench holds the centre button across consecutive edges while it changes address and data. A design that latched the write on the button edge would leave most of those registers stale. It also writes and reads the same register in one period: a registered read port would show the previous value, one cycle late. Every nibble from 0 to F is pushed through the display, which exposes a wrong or swapped segment code. Subtraction is run over all 64 operand pairs, so a reversed operand order or a wrong wrap-around shows up. All sixteen combinations of the four operation buttons are driven, which catches a wrong priority. A second reset in the middle of the run must zero every register as seen through both read ports.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  typedef enum logic [2:0] {
    SEL_PORT1 = 3'd0,
    SEL_PORT2 = 3'd1,
    SEL_SUM   = 3'd2,
    SEL_DIFF  = 3'd3,
    SEL_AND   = 3'd4
  } disp_sel_e;
endpackage

// File: rtl/rfd_reset_sync.sv
module rfd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rfd_regfile.sv
module rfd_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 4,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr1,
  input  logic [ADDR_W-1:0] rd_addr2,
  output logic [DATA_W-1:0] rd_data1,
  output logic [DATA_W-1:0] rd_data2
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];
  logic [DATA_W-1:0] mem_d [NUM_REGS];
  logic [NUM_REGS-1:0] row_en;

  // Address decode as an explicit per-row clock enable
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      row_en[r] = wr_en && (wr_addr == ADDR_W'(r));
      mem_d[r]  = row_en[r] ? wr_data : mem_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) mem_q[r] <= mem_d[r];
    end
  end

  assign rd_data1 = mem_q[rd_addr1];
  assign rd_data2 = mem_q[rd_addr2];

  // R2: a write request lands in the addressed row by the next edge
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    // R4: rows not addressed by a write keep their contents
    a_r4_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(g)) |=> $stable(mem_q[g]));
    // R5: every row reads zero while reset is applied
    a_r5_row_cleared: assert property (@(posedge clk)
      !rst_n |-> mem_q[g] == '0);
  end
endmodule

// File: rtl/rfd_result_sel.sv
module rfd_result_sel
  import rfd_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              pick_b,
  input  logic              do_sum,
  input  logic              do_diff,
  input  logic              do_and,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result
);
  disp_sel_e sel;

  always_comb begin
    if      (pick_b)  sel = SEL_PORT2;
    else if (do_sum)  sel = SEL_SUM;
    else if (do_diff) sel = SEL_DIFF;
    else if (do_and)  sel = SEL_AND;
    else              sel = SEL_PORT1;
  end

  always_comb begin
    unique case (sel)
      SEL_PORT2: result = opb;
      SEL_SUM:   result = opa + opb;
      SEL_DIFF:  result = opa - opb;
      SEL_AND:   result = opa & opb;
      default:   result = opa;
    endcase
  end
endmodule

// File: rtl/rfd_hex7seg.sv
module rfd_hex7seg (
  input  logic [3:0] nibble,
  output logic [6:0] seg_gfedcba_n
);
  always_comb begin
    unique case (nibble)
      4'h0: seg_gfedcba_n = 7'h40;
      4'h1: seg_gfedcba_n = 7'h79;
      4'h2: seg_gfedcba_n = 7'h24;
      4'h3: seg_gfedcba_n = 7'h30;
      4'h4: seg_gfedcba_n = 7'h19;
      4'h5: seg_gfedcba_n = 7'h12;
      4'h6: seg_gfedcba_n = 7'h02;
      4'h7: seg_gfedcba_n = 7'h78;
      4'h8: seg_gfedcba_n = 7'h00;
      4'h9: seg_gfedcba_n = 7'h10;
      4'hA: seg_gfedcba_n = 7'h08;
      4'hB: seg_gfedcba_n = 7'h03;
      4'hC: seg_gfedcba_n = 7'h46;
      4'hD: seg_gfedcba_n = 7'h21;
      4'hE: seg_gfedcba_n = 7'h06;
      default: seg_gfedcba_n = 7'h0E;
    endcase
  end
endmodule

// File: rtl/rfd_top.sv
module rfd_top #(
  parameter int NUM_REGS   = 8,
  parameter int DATA_W     = 4,
  parameter int NUM_DIGITS = 8,
  localparam int ADDR_W    = $clog2(NUM_REGS),
  localparam int SW_W      = DATA_W + 2 * ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SW_W-1:0]       sw,
  input  logic                  btn_center,
  input  logic                  btn_left,
  input  logic                  btn_right,
  input  logic                  btn_up,
  input  logic                  btn_down,
  output logic [7:0]            seg_n,
  output logic [NUM_DIGITS-1:0] an_n
);
  localparam int A1_LSB = DATA_W;
  localparam int A2_LSB = DATA_W + ADDR_W;
  localparam logic [NUM_DIGITS-1:0] DIGIT_EN_N = ~NUM_DIGITS'(1);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr1, addr2;
  logic [DATA_W-1:0] data_in, rd1, rd2, shown;
  logic [6:0]        glyph_n;

  assign data_in = sw[DATA_W-1:0];
  assign addr1   = sw[A1_LSB +: ADDR_W];
  assign addr2   = sw[A2_LSB +: ADDR_W];

  rfd_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  rfd_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(btn_center),
    .wr_addr(addr1), .wr_data(data_in),
    .rd_addr1(addr1), .rd_addr2(addr2),
    .rd_data1(rd1), .rd_data2(rd2)
  );

  rfd_result_sel #(.DATA_W(DATA_W)) u_sel (
    .pick_b(btn_right), .do_sum(btn_up), .do_diff(btn_down), .do_and(btn_left),
    .opa(rd1), .opb(rd2), .result(shown)
  );

  rfd_hex7seg u_hex (.nibble(shown[3:0]), .seg_gfedcba_n(glyph_n));

  assign seg_n = {1'b1, glyph_n};
  assign an_n  = DIGIT_EN_N;

  // R6: right button routes the second read port to the display path
  a_r6_right_shows_port2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    btn_right |-> shown == rd2);
  // R7/R8: up without right yields the modular sum of both ports
  a_r7_up_shows_sum: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!btn_right && btn_up) |-> shown == DATA_W'(rd1 + rd2));
endmodule

// File: tb/test_rfd_top.sv
`timescale 1ns/1ps
module test_rfd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [9:0] sw = '0;
  logic       bc = 0, bl = 0, br = 0, bu = 0, bd = 0;
  logic [7:0] seg_n, an_n;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string phase = "R5 reset";
  int    model [8];

  rfd_top i_rfd_top (
    .clk(clk), .rst_n(rst_n), .sw(sw), .btn_center(bc), .btn_left(bl),
    .btn_right(br), .btn_up(bu), .btn_down(bd), .seg_n(seg_n), .an_n(an_n)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] glyph(int v);
    case (v & 15)
      0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
      4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
      8: return 7'h00;  9: return 7'h10; 10: return 7'h08; 11: return 7'h03;
     12: return 7'h46; 13: return 7'h21; 14: return 7'h06; default: return 7'h0E;
    endcase
  endfunction

  // behavioural reference state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int k = 0; k < 8; k++) model[k] = 0;
    else if (bc) model[sw[6:4]] = int'(sw[3:0]);
  end

  function automatic int expect_val();
    int a = model[sw[6:4]];
    int b = model[sw[9:7]];
    if (br) return b;
    if (bu) return (a + b) & 15;
    if (bd) return (a - b) & 15;
    if (bl) return a & b;
    return a;
  endfunction

  // compare a few ns after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!done) begin
        logic [7:0] exp_seg;
        exp_seg = {1'b1, glyph(expect_val())};
        n_cmp++;
        if (seg_n !== exp_seg) begin
          n_bad++;
          $display("FAIL %s: seg_n actual %b expected %b (sw=%b c%0b l%0b r%0b u%0b d%0b)",
                   phase, seg_n, exp_seg, sw, bc, bl, br, bu, bd);
        end
        n_cmp++;
        if (an_n !== 8'b1111_1110) begin
          n_bad++;
          $display("FAIL R10: an_n actual %b expected 11111110", an_n);
        end
      end
    end
  end

  task automatic drive(input int a1, input int a2, input int d, input bit c,
                       input bit l, input bit r, input bit u, input bit dn);
    @(negedge clk);
    sw = {3'(a2), 3'(a1), 4'(d)};
    bc = c; bl = l; br = r; bu = u; bd = dn;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) drive(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) drive(0, 0, 0, 0, 0, 0, 0, 0);

    phase = "R1 R2 R3 level write with same-period readback";
    for (int i = 0; i < 8; i++) drive(i, 7 - i, (i * 5 + 3) & 15, 1, 0, 0, 0, 0);

    phase = "R4 registers hold without write enable";
    for (int i = 0; i < 8; i++) drive(i, i, 15 - i, 0, 0, 0, 0, 0);

    phase = "R9 every hex glyph";
    for (int v = 0; v < 16; v++) drive(0, 0, v, 1, 0, 0, 0, 0);

    phase = "R2 reload";
    for (int i = 0; i < 8; i++) drive(i, 0, (i * 7 + 9) & 15, 1, 0, 0, 0, 0);

    phase = "R6 port-2 select";
    for (int i = 0; i < 8; i++) drive(i, (i + 3) & 7, 0, 0, 0, 1, 0, 0);

    phase = "R7 sum";
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) drive(i, j, 0, 0, 0, 0, 1, 0);
    phase = "R7 difference";
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) drive(i, j, 0, 0, 0, 0, 0, 1);
    phase = "R7 and";
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) drive(i, j, 0, 0, 1, 0, 0, 0);

    phase = "R8 button priority";
    for (int m = 0; m < 16; m++)
      for (int i = 0; i < 8; i += 3) drive(i, 7 - i, 0, 0, m[3], m[0], m[1], m[2]);

    phase = "R5 reset clears all registers";
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 8; i++) drive(i, 7 - i, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) drive(i, i, 0, 0, 0, 1, 0, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) drive(0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) drive(i, 7 - i, 0, 0, 0, 0, 0, 0);

    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule